// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This peripheral keeps time as a 32-bit count of seconds. A prescaler divides the input clock by a fixed parameter to make a one-second tick, and the count advances only on that tick. Software reaches the block through a flat 32-bit register bus. The bus has an address, a write strobe with write data, and a read strobe. Read data is decoded combinationally from the address in the same cycle.

A new time value is written into a staging register. It replaces the count only at the next tick, so the count never moves between two ticks. A match register sets an alarm. When the count takes the match value, a sticky pending flag is set. That flag is gated by an enable bit and a mask bit to drive a level interrupt. Reading a dedicated acknowledge location clears the flag. Control bits choose whether the count wraps past its top value or stops there.

Top module: `secs_rtc`

## Requirements
- R1: Register offsets on `bus_addr`: 0x00 count, 0x04 match, 0x08 staged load value, 0x0C control, 0x10 gated status, 0x14 raw status, 0x18 acknowledge, 0x1C version. The read data for the address on `bus_addr` appears in the same cycle. After reset, count, match, load, control and both status words read 0, and `alarm_irq` is 0.
- R2: While the run bit (control bit 2) is 1, the count rises by exactly one every `TICK_DIV` clock cycles. The first step comes `TICK_DIV` cycles after the run bit is written to 1 from reset.
- R3: While the run bit is 0, both the count and the prescaler phase hold. When the run bit is set again, counting resumes from the held phase.
- R4: A value written at offset 0x08 does not change the count before the next tick. At that tick the count becomes exactly that value. A staged value survives a stop.
- R5: With the wrap bit (control bit 3) at 1, a tick at 0xFFFFFFFF gives 0. With it at 0, the count stays at 0xFFFFFFFF.
- R6: Raw status bit 0 becomes 1 one clock after the count takes the match value. This happens whatever the enable and mask bits are, and the bit stays set until it is acknowledged.
- R7: Gated status bit 0 and `alarm_irq` equal raw pending AND enable (control bit 0) AND NOT mask (control bit 1).
- R8: A read strobe at offset 0x18 clears the pending flag at the next edge. A write to offset 0x18 has no effect on it.
- R9: If a match event and an acknowledge read occur in the same cycle, the pending flag stays set.
- R10: Offsets 0x00 and 0x1C are read-only. Offset 0x1C always returns `VERSION`.
- R11: The control register keeps only bits 3:0. The upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe, used for the acknowledge side effect |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
Properties guard the following on every cycle:
- the prescaler never ticks on two cycles in a row and never ticks while stopped;
- the count is stable between ticks, even across a load write;
- saturation holds at the top value;
- the interrupt is silent whenever it is disabled or masked;
- an acknowledge without a coincident match clears the flag, and a coincident match keeps it.

Only the bench's scenarios show the rest:
- the exact tick cadence and the phase kept across a stop;
- a staged load appearing on the right tick;
- wrap to zero;
- the full enable/mask sweep;
- writes to the read-only and acknowledge locations having no effect.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int unsigned DATA_W = 32;

    localparam logic [4:0] OFS_COUNT  = 5'h00;
    localparam logic [4:0] OFS_MATCH  = 5'h04;
    localparam logic [4:0] OFS_LOAD   = 5'h08;
    localparam logic [4:0] OFS_CTRL   = 5'h0C;
    localparam logic [4:0] OFS_GATED  = 5'h10;
    localparam logic [4:0] OFS_RAW    = 5'h14;
    localparam logic [4:0] OFS_ACK    = 5'h18;
    localparam logic [4:0] OFS_VER    = 5'h1C;

    // packed MSB first: bit3 wrap, bit2 run, bit1 mask, bit0 enable
    typedef struct packed {
        logic wrap_en;
        logic run_en;
        logic irq_mask;
        logic irq_en;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] step_count(
        input logic [DATA_W-1:0] cur,
        input logic              wrap
    );
        if (cur == {DATA_W{1'b1}})
            return wrap ? '0 : cur;
        return cur + 1'b1;
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase;

            always_ff @(posedge clk) begin
                if (rst)
                    phase <= '0;
                else if (en)
                    phase <= (phase == LAST) ? '0 : phase + 1'b1;
            end

            assign tick = en && (phase == LAST);

            assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end else begin : g_nodiv
            assign tick = en;
        end
    endgenerate

    assert_tick_stopped_R3: assert property (@(posedge clk) disable iff (rst)
        !en |-> !tick);
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wrap_en,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] staged,
    output logic              updated
);
    logic stage_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            count      <= '0;
            staged     <= '0;
            stage_pend <= 1'b0;
            updated    <= 1'b0;
        end else begin
            updated <= tick;
            if (tick) begin
                count      <= stage_pend ? staged : step_count(count, wrap_en);
                stage_pend <= 1'b0;
            end
            if (load_wr) begin
                staged     <= load_val;
                stage_pend <= 1'b1;
            end
        end
    end

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    assert_load_deferred_R4: assert property (@(posedge clk) disable iff (rst)
        (load_wr && !tick) |=> (count == $past(count)));

    assert_saturate_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !stage_pend && !wrap_en && count == {DATA_W{1'b1}}) |=> (count == {DATA_W{1'b1}}));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              updated,
    input  logic [DATA_W-1:0] count,
    input  logic [DATA_W-1:0] match,
    input  logic              ack,
    input  logic              irq_en,
    input  logic              irq_mask,
    output logic              raw_pend,
    output logic              irq
);
    logic hit;

    assign hit = updated && (count == match);

    always_ff @(posedge clk) begin
        if (rst)
            raw_pend <= 1'b0;
        else if (hit)
            raw_pend <= 1'b1;
        else if (ack)
            raw_pend <= 1'b0;
    end

    assign irq = raw_pend & irq_en & ~irq_mask;

    assert_hit_sets_R6: assert property (@(posedge clk) disable iff (rst)
        hit |=> raw_pend);

    assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (!irq_en || irq_mask) |-> !irq);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (ack && !hit) |=> !raw_pend);

    assert_hit_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && hit) |=> raw_pend);
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
    import rtc_pkg::*;
#(
    parameter int unsigned    TICK_DIV = 32768,
    parameter int unsigned    ADDR_W   = 5,
    parameter logic [31:0]    VERSION  = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd_en,
    output logic [31:0]       bus_rdata,
    output logic              alarm_irq
);
    localparam int unsigned CTRL_W = $bits(ctrl_t);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] match_q;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] staged;
    logic              tick;
    logic              updated;
    logic              raw_pend;
    logic              irq;

    logic sel_match, sel_load, sel_ctrl, sel_ack;
    assign sel_match = (bus_addr == ADDR_W'(OFS_MATCH));
    assign sel_load  = (bus_addr == ADDR_W'(OFS_LOAD));
    assign sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_ack   = (bus_addr == ADDR_W'(OFS_ACK));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            match_q <= '0;
        end else if (bus_wr_en) begin
            if (sel_ctrl)
                ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (sel_match)
                match_q <= bus_wdata;
        end
    end

    rtc_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .en   (ctrl.run_en),
        .tick (tick)
    );

    rtc_counter u_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wrap_en  (ctrl.wrap_en),
        .load_wr  (bus_wr_en && sel_load),
        .load_val (bus_wdata),
        .count    (count),
        .staged   (staged),
        .updated  (updated)
    );

    rtc_alarm u_alarm (
        .clk      (clk),
        .rst      (rst),
        .updated  (updated),
        .count    (count),
        .match    (match_q),
        .ack      (bus_rd_en && sel_ack),
        .irq_en   (ctrl.irq_en),
        .irq_mask (ctrl.irq_mask),
        .raw_pend (raw_pend),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_COUNT): bus_rdata = count;
            ADDR_W'(OFS_MATCH): bus_rdata = match_q;
            ADDR_W'(OFS_LOAD):  bus_rdata = staged;
            ADDR_W'(OFS_CTRL):  bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl};
            ADDR_W'(OFS_GATED): bus_rdata = {31'd0, irq};
            ADDR_W'(OFS_RAW):   bus_rdata = {31'd0, raw_pend};
            ADDR_W'(OFS_VER):   bus_rdata = VERSION;
            default:            bus_rdata = '0;
        endcase
    end

    assign alarm_irq = irq;

    assert_match_write_only_R1: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr_en && sel_match) |=> $stable(match_q));
endmodule

// File: tb/secs_rtc_tb.sv
module secs_rtc_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int unsigned DIV        = 4;
    localparam logic [31:0] VER        = 32'h0A0B_0C0D;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secs_rtc #(.TICK_DIV(DIV), .ADDR_W(5), .VERSION(VER)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
        .alarm_irq(alarm_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(posedge clk); #1;
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_rd_en = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_count(input logic [31:0] target, input string req);
        logic [31:0] v;
        logic found = 1'b0;
        for (int i = 0; i < 64; i++) begin
            @(posedge clk); #1;
            peek(5'h00, v);
            if (v == target) begin
                found = 1'b1;
                break;
            end
        end
        chk(req, {31'd0, found}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog R2 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, c;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values
        peek(5'h00, v); chk("R1 count reset", v, 0);
        peek(5'h04, v); chk("R1 match reset", v, 0);
        peek(5'h08, v); chk("R1 load reset", v, 0);
        peek(5'h0C, v); chk("R1 ctrl reset", v, 0);
        peek(5'h10, v); chk("R1 gated reset", v, 0);
        peek(5'h14, v); chk("R1 raw reset", v, 0);
        chk("R1 irq reset", {31'd0, alarm_irq}, 0);

        // R10 read-only locations
        wr(5'h00, 32'd55);
        wr(5'h1C, 32'd0);
        peek(5'h00, v); chk("R10 count write ignored", v, 0);
        peek(5'h1C, v); chk("R10 version", v, VER);

        // R11 control width
        wr(5'h0C, 32'hFFFF_FFF0);
        peek(5'h0C, v); chk("R11 upper ctrl bits", v, 0);

        // R4 staged load while stopped
        wr(5'h08, 32'd100);
        peek(5'h08, v); chk("R1 load readback", v, 100);
        repeat (20) @(posedge clk);
        #1 peek(5'h00, v); chk("R4 load held while stopped", v, 0);

        // R2 cadence, R4 load at first tick
        wr(5'h0C, 32'h4);
        repeat (3) begin
            @(posedge clk); #1 peek(5'h00, v); chk("R4 not before tick", v, 0);
        end
        @(posedge clk); #1 peek(5'h00, v); chk("R4 load at tick", v, 100);
        for (int k = 1; k <= 4; k++) begin
            repeat (3) begin
                @(posedge clk); #1 peek(5'h00, v); chk("R2 steady between ticks", v, 99 + k);
            end
            @(posedge clk); #1 peek(5'h00, v); chk("R2 step per period", v, 100 + k);
        end

        // R3 stop keeps count and prescaler phase
        wr(5'h0C, 32'h0);
        repeat (20) @(posedge clk);
        #1 peek(5'h00, v); chk("R3 count held", v, 104);
        wr(5'h0C, 32'h4);
        repeat (2) begin
            @(posedge clk); #1 peek(5'h00, v); chk("R3 resume phase hold", v, 104);
        end
        @(posedge clk); #1 peek(5'h00, v); chk("R3 resume phase step", v, 105);

        // R5 saturation then wrap
        wr(5'h08, 32'hFFFF_FFFE);
        wait_count(32'hFFFF_FFFE, "R4 load seen");
        wait_count(32'hFFFF_FFFF, "R5 reach top");
        repeat (12) @(posedge clk);
        #1 peek(5'h00, v); chk("R5 saturate", v, 32'hFFFF_FFFF);
        wr(5'h0C, 32'hC);
        wait_count(32'h0, "R5 wrap to zero");
        peek(5'h14, v); chk("R6 raw not yet", v, 0);
        @(posedge clk); #1 peek(5'h14, v); chk("R6 raw after match", v, 1);

        // R8 acknowledge
        wr(5'h18, 32'hFFFF_FFFF);
        peek(5'h14, v); chk("R8 ack write ignored", v, 1);
        rd(5'h18, v);
        peek(5'h14, v); chk("R8 ack read clears", v, 0);

        // R6/R7 sweep over enable and mask
        peek(5'h00, c);
        wr(5'h04, c + 3);
        wait_count(c + 3, "R6 reach match");
        peek(5'h14, v); chk("R6 raw one cycle later", v, 0);
        @(posedge clk); #1 peek(5'h14, v); chk("R6 raw regardless of gate", v, 1);
        peek(5'h10, v); chk("R7 gated off", v, 0);
        chk("R7 irq off", {31'd0, alarm_irq}, 0);
        for (int g = 0; g < 4; g++) begin
            logic ie, mk;
            ie = g[0]; mk = g[1];
            wr(5'h0C, 32'hC | {30'd0, mk, ie});
            peek(5'h10, v); chk("R7 gated status", v, {31'd0, ie & ~mk});
            chk("R7 irq pin", {31'd0, alarm_irq}, {31'd0, ie & ~mk});
            peek(5'h14, v); chk("R6 raw sticky", v, 1);
        end

        // R9 match coincident with acknowledge
        wr(5'h0C, 32'hD);
        rd(5'h18, v);
        peek(5'h00, c);
        wr(5'h04, c + 2);
        wait_count(c + 2, "R9 reach match");
        bus_addr = 5'h18; bus_rd_en = 1'b1;
        @(posedge clk); #1 bus_rd_en = 1'b0;
        peek(5'h14, v); chk("R9 event wins", v, 1);
        chk("R9 irq kept", {31'd0, alarm_irq}, 1);
        rd(5'h18, v);
        peek(5'h14, v); chk("R8 cleared after", v, 0);
        chk("R8 irq cleared", {31'd0, alarm_irq}, 0);
        peek(5'h04, v); chk("R1 match readback", v, c + 2);
        peek(5'h1C, v); chk("R10 version stable", v, VER);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule